// File: doc/BRIEF.md
# Pin Bank Controller with Set/Clear Registers

The block controls a bank of general-purpose pins from a small register bus. Each piece of per-pin control state (pin ownership, output level, driver enable, interrupt mask and alternate-function choice) lives in one register. Software changes that register through two write-only addresses. Writing ones to the first address sets the chosen bits and writing ones to the second address clears them. Software never needs a read-modify-write, and bits written as zero keep their value.

Every pin is either owned by the general-purpose function or handed to one of two peripheral signal sets, called side A and side B. A per-pin pad mux selects the output level and driver enable from whichever owner the pin has. The pad inputs pass through a synchronizer. The synchronized levels feed a readable level register and a change detector. Changes collect in an interrupt status register, which is cleared when it is read. A single interrupt line stays high while any collected change is also unmasked.

The register bus completes in one cycle. A write takes effect at the clock edge of its cycle. Read data is a combinational function of the address. Because one offset is cleared by reading it, reads carry their own strobe.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset, every pin is owned by the general-purpose function and its driver is off. The output latch, the interrupt mask and the interrupt status read 0, side A is selected on every pin, and the interrupt line is low.
- R2: A write to 0x30 sets the output latch bits where the written data has ones. A write to 0x34 clears the output latch bits where the written data has ones. Zero bits leave the latch unchanged. The latch reads back at 0x38.
- R3: A write to 0x10 sets driver-enable bits and a write to 0x14 clears them; the state reads back at 0x18. For pins owned by the general-purpose function, the pad driver enable follows this state and the pad output follows the output latch.
- R4: Writes to the driver-enable addresses leave the output latch unchanged, so a level written while a pin is an input is driven once the driver is enabled.
- R5: A write to 0x00 gives pins to the general-purpose function and a write to 0x04 hands them to a peripheral. The ownership state reads at 0x08, with 1 meaning general-purpose. A peripheral-owned pin takes its output and driver enable from the selected peripheral side.
- R6: A write to 0x74 selects side B and a write to 0x70 selects side A. The select state reads at 0x78, with 1 meaning side B.
- R7: Offset 0x3C returns every pad level after two synchronizer stages, whatever the pin's direction. A pad change is visible on the second clock edge after it, and not on the first.
- R8: A write to 0x40 sets interrupt-mask bits and a write to 0x44 clears them; the mask reads at 0x48. Writing all ones to 0x44 masks every pin.
- R9: A change of a synchronized level sets that pin's bit at 0x4C on the third edge after the pad change. A read of 0x4C returns the collected bits and clears them. A change that lands on the same edge as the read is kept for the next read.
- R10: The interrupt line is high exactly while some pin has both its status bit and its mask bit set. It drops once the status bits are read away or the mask bits are cleared.
- R11: Writes to the read-only offsets 0x08, 0x18, 0x38, 0x48 and 0x78 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for clear-on-read) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad driver enables |
| side_a_out | input | NPINS | Side A output levels |
| side_a_oe | input | NPINS | Side A driver enables |
| side_a_in | output | NPINS | Pad levels for pins assigned to side A, 0 elsewhere |
| side_b_out | input | NPINS | Side B output levels |
| side_b_oe | input | NPINS | Side B driver enables |
| side_b_in | output | NPINS | Pad levels for pins assigned to side B, 0 elsewhere |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: 32 pins and two synchronizer stages. With those values the top pin (bit 31) and full-word all-ones masks are exercised. The pad-to-register latency can be checked edge by edge, both just before and just after each register stage. These settings also reach the case where a pin change is captured on the same edge as a status read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int BUS_W  = 32;
   localparam int ADDR_W = 8;

   localparam logic [ADDR_W-1:0] OFS_OWN_SET  = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_OWN_CLR  = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_OWN_STAT = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_OE_SET   = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_OE_CLR   = 8'h14;
   localparam logic [ADDR_W-1:0] OFS_OE_STAT  = 8'h18;
   localparam logic [ADDR_W-1:0] OFS_DO_SET   = 8'h30;
   localparam logic [ADDR_W-1:0] OFS_DO_CLR   = 8'h34;
   localparam logic [ADDR_W-1:0] OFS_DO_STAT  = 8'h38;
   localparam logic [ADDR_W-1:0] OFS_LVL_STAT = 8'h3C;
   localparam logic [ADDR_W-1:0] OFS_IM_SET   = 8'h40;
   localparam logic [ADDR_W-1:0] OFS_IM_CLR   = 8'h44;
   localparam logic [ADDR_W-1:0] OFS_IM_STAT  = 8'h48;
   localparam logic [ADDR_W-1:0] OFS_CHG_STAT = 8'h4C;
   localparam logic [ADDR_W-1:0] OFS_SEL_A    = 8'h70;
   localparam logic [ADDR_W-1:0] OFS_SEL_B    = 8'h74;
   localparam logic [ADDR_W-1:0] OFS_SEL_STAT = 8'h78;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_w1sc_reg.sv
module gpio_w1sc_reg #(
   parameter int          WIDTH = 32,
   parameter logic [31:0] RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] set_m, clr_m;
   assign set_m = set_en ? mask : '0;
   assign clr_m = clr_en ? mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RESET[WIDTH-1:0];
      else        q <= (q & ~clr_m) | set_m;
   end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] own_gpio,
   input  logic [WIDTH-1:0] use_b,
   input  logic [WIDTH-1:0] gp_out,
   input  logic [WIDTH-1:0] gp_oe,
   input  logic [WIDTH-1:0] a_out,
   input  logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_out,
   input  logic [WIDTH-1:0] b_oe,
   input  logic [WIDTH-1:0] pad_lvl,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] b_in
);
   for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      always_comb begin
         if (own_gpio[p]) begin
            pad_out[p] = gp_out[p];
            pad_oe[p]  = gp_oe[p];
         end else if (use_b[p]) begin
            pad_out[p] = b_out[p];
            pad_oe[p]  = b_oe[p];
         end else begin
            pad_out[p] = a_out[p];
            pad_oe[p]  = a_oe[p];
         end
      end
      assign a_in[p] = pad_lvl[p] & ~own_gpio[p] & ~use_b[p];
      assign b_in[p] = pad_lvl[p] & ~own_gpio[p] &  use_b[p];
   end
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   input  logic [NPINS-1:0]  side_a_out,
   input  logic [NPINS-1:0]  side_a_oe,
   output logic [NPINS-1:0]  side_a_in,
   input  logic [NPINS-1:0]  side_b_out,
   input  logic [NPINS-1:0]  side_b_oe,
   output logic [NPINS-1:0]  side_b_in,
   output logic              irq
);
   localparam int PAD_W = BUS_W - NPINS;

   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $error("NPINS must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] wmask;
   assign wmask = bus_wdata[NPINS-1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] ofs);
      return bus_wr && (a == ofs);
   endfunction

   logic [NPINS-1:0] own_q, oe_q, do_q, im_q, sel_q;

   gpio_w1sc_reg #(.WIDTH(NPINS), .RESET('1)) u_own (
      .clk(clk), .rst_n(rst_n), .set_en(hit(bus_addr, OFS_OWN_SET)),
      .clr_en(hit(bus_addr, OFS_OWN_CLR)), .mask(wmask), .q(own_q));
   gpio_w1sc_reg #(.WIDTH(NPINS), .RESET('0)) u_oe (
      .clk(clk), .rst_n(rst_n), .set_en(hit(bus_addr, OFS_OE_SET)),
      .clr_en(hit(bus_addr, OFS_OE_CLR)), .mask(wmask), .q(oe_q));
   gpio_w1sc_reg #(.WIDTH(NPINS), .RESET('0)) u_do (
      .clk(clk), .rst_n(rst_n), .set_en(hit(bus_addr, OFS_DO_SET)),
      .clr_en(hit(bus_addr, OFS_DO_CLR)), .mask(wmask), .q(do_q));
   gpio_w1sc_reg #(.WIDTH(NPINS), .RESET('0)) u_im (
      .clk(clk), .rst_n(rst_n), .set_en(hit(bus_addr, OFS_IM_SET)),
      .clr_en(hit(bus_addr, OFS_IM_CLR)), .mask(wmask), .q(im_q));
   gpio_w1sc_reg #(.WIDTH(NPINS), .RESET('0)) u_sel (
      .clk(clk), .rst_n(rst_n), .set_en(hit(bus_addr, OFS_SEL_B)),
      .clr_en(hit(bus_addr, OFS_SEL_A)), .mask(wmask), .q(sel_q));

   logic [NPINS-1:0] lvl_q, lvl_prev_q, chg, isr_q;
   logic             isr_rd;

   gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_q));

   assign chg    = lvl_q ^ lvl_prev_q;
   assign isr_rd = bus_rd && (bus_addr == OFS_CHG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev_q <= '0;
         isr_q      <= '0;
      end else begin
         lvl_prev_q <= lvl_q;
         isr_q      <= isr_rd ? chg : (isr_q | chg);
      end
   end

   assign irq = |(isr_q & im_q);

   gpio_pad_mux #(.WIDTH(NPINS)) u_mux (
      .own_gpio(own_q), .use_b(sel_q), .gp_out(do_q), .gp_oe(oe_q),
      .a_out(side_a_out), .a_oe(side_a_oe), .b_out(side_b_out), .b_oe(side_b_oe),
      .pad_lvl(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .a_in(side_a_in), .b_in(side_b_in));

   logic [NPINS-1:0] rd_sel;
   always_comb begin
      unique case (bus_addr)
         OFS_OWN_STAT: rd_sel = own_q;
         OFS_OE_STAT:  rd_sel = oe_q;
         OFS_DO_STAT:  rd_sel = do_q;
         OFS_LVL_STAT: rd_sel = lvl_q;
         OFS_IM_STAT:  rd_sel = im_q;
         OFS_CHG_STAT: rd_sel = isr_q;
         OFS_SEL_STAT: rd_sel = sel_q;
         default:      rd_sel = '0;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign bus_rdata = {{PAD_W{1'b0}}, rd_sel};
   end else begin : g_full
      assign bus_rdata = rd_sel;
   end
endmodule

// File: rtl/gpio_setclr_bank_chk.sv
module gpio_setclr_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NPINS = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [NPINS-1:0]  do_q,
   input logic [NPINS-1:0]  im_q,
   input logic [NPINS-1:0]  isr_q,
   input logic [NPINS-1:0]  chg,
   input logic              irq
);
   // R2: set-data write forces the masked latch bits high
   a_r2_set_data: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_DO_SET) |=>
      ((do_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

   // R2: clear-data write forces the masked latch bits low
   a_r2_clr_data: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_DO_CLR) |=> ((do_q & $past(bus_wdata[NPINS-1:0])) == '0));

   // R4: driver-enable writes leave the output latch alone
   a_r4_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == OFS_OE_SET || bus_addr == OFS_OE_CLR)) |=> $stable(do_q));

   // R8: mask-clear write drops the masked bits
   a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_IM_CLR) |=> ((im_q & $past(bus_wdata[NPINS-1:0])) == '0));

   // R9: after a status read only same-edge changes remain
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_CHG_STAT) |=> ((isr_q & ~$past(chg)) == '0));

   // R10: the interrupt line needs an unmasked pin
   a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (im_q != '0));
endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(.NPINS(NPINS)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .do_q(do_q), .im_q(im_q), .isr_q(isr_q), .chg(chg), .irq(irq));

// File: tb/test_gpio_setclr_bank.sv
module test_gpio_setclr_bank;
   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pad_in = '0, pad_out, pad_oe;
   logic [N-1:0]  side_a_out = '0, side_a_oe = '0, side_a_in;
   logic [N-1:0]  side_b_out = '0, side_b_oe = '0, side_b_in;
   logic          irq;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   gpio_setclr_bank #(.NPINS(N), .SYNC_STAGES(2)) i_gpio_setclr_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .side_a_out(side_a_out), .side_a_oe(side_a_oe), .side_a_in(side_a_in),
      .side_b_out(side_b_out), .side_b_oe(side_b_oe), .side_b_in(side_b_in), .irq(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset;
      rd_chk("R1 own", 8'h08, 32'hFFFF_FFFF);
      rd_chk("R1 oe", 8'h18, 32'h0);
      rd_chk("R1 data", 8'h38, 32'h0);
      rd_chk("R1 mask", 8'h48, 32'h0);
      rd_chk("R1 sel", 8'h78, 32'h0);
      rd_chk("R1 chg", 8'h4C, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 pad_oe", pad_oe, 32'h0);
   endtask

   task automatic t_data;
      wr(8'h30, 32'h8000_00F0);
      rd_chk("R2 set", 8'h38, 32'h8000_00F0);
      wr(8'h34, 32'h0000_0030);
      rd_chk("R2 clr", 8'h38, 32'h8000_00C0);
      check("R3 pad_out latch", pad_out, 32'h8000_00C0);
   endtask

   task automatic t_oe;
      wr(8'h10, 32'h0000_00FF);
      rd_chk("R3 oe set", 8'h18, 32'h0000_00FF);
      check("R3 pad_oe", pad_oe, 32'h0000_00FF);
      rd_chk("R4 latch after oe", 8'h38, 32'h8000_00C0);
      wr(8'h14, 32'h0000_000F);
      rd_chk("R3 oe clr", 8'h18, 32'h0000_00F0);
      rd_chk("R4 latch kept", 8'h38, 32'h8000_00C0);
   endtask

   task automatic t_owner;
      side_a_out = '1; side_a_oe = '1;
      wr(8'h04, 32'h0000_FF00);
      rd_chk("R5 own clr", 8'h08, 32'hFFFF_00FF);
      check("R5 pad_oe side A", pad_oe, 32'h0000_FFF0);
      wr(8'h74, 32'h0000_F000);
      rd_chk("R6 sel B", 8'h78, 32'h0000_F000);
      check("R6 pad_oe side B", pad_oe, 32'h0000_0FF0);
      check("R6 pad_out mix", pad_out, 32'h8000_0FC0);
      wr(8'h70, 32'h0000_F000);
      rd_chk("R6 sel A", 8'h78, 32'h0);
      wr(8'h00, 32'h0000_FF00);
      rd_chk("R5 own set", 8'h08, 32'hFFFF_FFFF);
      check("R5 pad_oe gpio", pad_oe, 32'h0000_00F0);
      side_a_out = '0; side_a_oe = '0;
   endtask

   task automatic t_level;
      logic [31:0] v;
      pad_in = 32'hA5A5_0001;
      @(negedge clk);
      rd(8'h3C, v);
      check("R7 not after one edge", v, 32'h0);
      rd_chk("R7 level", 8'h3C, 32'hA5A5_0001);
      rd_chk("R9 chg collect", 8'h4C, 32'hA5A5_0001);
      check("R10 masked no irq", {31'b0, irq}, 32'h0);
      rd_chk("R9 chg cleared", 8'h4C, 32'h0);
   endtask

   task automatic t_irq;
      wr(8'h40, 32'h0000_0001);
      rd_chk("R8 mask set", 8'h48, 32'h0000_0001);
      pad_in[0] = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R10 irq before capture", {31'b0, irq}, 32'h0);
      @(negedge clk);
      check("R10 irq raised", {31'b0, irq}, 32'h1);
      rd_chk("R9 chg pin0", 8'h4C, 32'h0000_0001);
      check("R10 irq dropped", {31'b0, irq}, 32'h0);
      pad_in[5] = 1'b1;
      repeat (4) @(negedge clk);
      check("R10 masked pin5", {31'b0, irq}, 32'h0);
      rd_chk("R9 chg pin5", 8'h4C, 32'h0000_0020);
      wr(8'h40, 32'h8000_0000);
      wr(8'h44, 32'hFFFF_FFFF);
      rd_chk("R8 all masked", 8'h48, 32'h0);
   endtask

   task automatic t_same_edge;
      logic [31:0] v;
      pad_in[1] = 1'b1;
      @(negedge clk); @(negedge clk);
      rd(8'h4C, v);
      check("R9 read before capture", v, 32'h0);
      rd_chk("R9 same-edge kept", 8'h4C, 32'h0000_0002);
   endtask

   task automatic t_readonly;
      wr(8'h08, 32'h0); wr(8'h18, 32'hFFFF_FFFF); wr(8'h38, 32'h0);
      wr(8'h48, 32'hFFFF_FFFF); wr(8'h78, 32'hFFFF_FFFF);
      rd_chk("R11 own", 8'h08, 32'hFFFF_FFFF);
      rd_chk("R11 oe", 8'h18, 32'h0000_00F0);
      rd_chk("R11 data", 8'h38, 32'h8000_00C0);
      rd_chk("R11 mask", 8'h48, 32'h0);
      rd_chk("R11 sel", 8'h78, 32'h0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_data();
            t_oe();
            t_owner();
            t_level();
            t_irq();
            t_same_edge();
            t_readonly();
         end
         begin
            repeat (5000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule